// File: doc/BRIEF.md
# Zig-Zag Coefficient Reorder Buffer

This block takes the 64 coefficients of one 8x8 transform block, presented in row-major order, and returns them in zig-zag scan order, the order used before run-length coding of image blocks. Each coefficient is placed at its scan position when it is written, so reading out is a simple count from 0 to 63.

Storage is split into two banks of 64 entries. One bank fills while the other drains, so a steady stream of blocks passes through with no idle cycles once the first block is complete. Both sides use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The source may hold `in_valid` low at any time. When both banks hold blocks that have not yet been read, `in_ready` goes low and the source must wait. When `out_ready` is low, the output holds its current coefficient. The coefficient width is a parameter.

Top module: `zigzag_reorder`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The natural sample n of a block (row-major index, 0..63) leaves at output position P[n], with P = 0,1,5,6,14,15,27,28, 2,4,7,13,16,26,29,42, 3,8,12,17,25,30,41,43, 9,11,18,24,31,40,44,53, 10,19,23,32,39,45,52,54, 20,22,33,38,46,51,55,60, 21,34,37,47,50,56,59,61, 35,36,48,49,57,58,62,63. For example, sample 0 stays at position 0 and sample 2 leaves at position 5.
- R3: `out_last` is 1 together with output position 63 of each block and is 0 for positions 0 to 62.
- R4: Output position 0 of a block is valid in the cycle right after the clock edge that accepts that block's 64th sample, provided the other bank has already been drained.
- R5: When input is continuous and `out_ready` stays high, output coefficients follow each other on consecutive cycles across block boundaries.
- R6: `in_ready` is 0 whenever two complete blocks are waiting to be read. With the output stalled, at most 128 samples are accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` and `out_last` unchanged.
- R8: A sample accepted with `in_sob`=1 becomes natural index 0 of a new block. Any partly written block is dropped and never appears at the output.
- R9: Cycles with `in_valid`=0 insert no sample. Gaps at the input and stalls at the output do not change the order of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input coefficient is valid |
| in_ready | output | 1 | Block can accept a coefficient |
| in_sob | input | 1 | Marks the first coefficient of a block |
| in_data | input | COEF_W | Coefficient in row-major order |
| out_valid | output | 1 | Output coefficient is valid |
| out_ready | input | 1 | Sink accepts the output coefficient |
| out_data | output | COEF_W | Coefficient in zig-zag order |
| out_last | output | 1 | Marks scan position 63 |

## Verification
Inputs are driven, and outputs observed, on the falling clock edge. A transfer is therefore logged for the rising edge that follows. A block becomes readable at the edge that accepts its 64th sample, so position 0 is checked one cycle after that logged input cycle. Every later position of a streaming run is checked exactly one cycle after the previous one. Stall and drop checks look at the ports after a wait of hundreds of cycles, long enough for any wrongly accepted or released data to have shown up.

// File: rtl/zz_pkg.sv
package zz_pkg;

  localparam int ZZ_DIM = 8;
  localparam int ZZ_N   = ZZ_DIM * ZZ_DIM;
  localparam int ZZ_AW  = $clog2(ZZ_N);

  // Scan position of row-major index n, derived from the anti-diagonal
  // it lies on and the direction in which that diagonal is walked.
  function automatic logic [ZZ_AW-1:0] zz_pos(input logic [ZZ_AW-1:0] n);
    int r;
    int c;
    int d;
    int lo;
    int base;
    int off;
    r    = int'(n) / ZZ_DIM;
    c    = int'(n) % ZZ_DIM;
    d    = r + c;
    lo   = (d < ZZ_DIM) ? 0 : d - (ZZ_DIM - 1);
    base = (d < ZZ_DIM) ? (d * (d + 1)) / 2
                        : ZZ_N - ((2 * ZZ_DIM - 1 - d) * (2 * ZZ_DIM - d)) / 2;
    off  = d[0] ? (r - lo) : (c - lo);
    return ZZ_AW'(base + off);
  endfunction

endpackage

// File: rtl/zz_wr_seq.sv
module zz_wr_seq
  import zz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sob,
  output logic [ZZ_AW-1:0] addr,
  output logic             done
);

  logic [ZZ_AW-1:0] idx_q;
  logic [ZZ_AW-1:0] cur;

  // A start marker forces the index back to zero.
  assign cur  = sob ? '0 : idx_q;
  assign addr = zz_pos(cur);
  assign done = fire && (cur == ZZ_AW'(ZZ_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (fire) idx_q <= cur + 1'b1;
  end

endmodule

// File: rtl/zz_rd_seq.sv
module zz_rd_seq
  import zz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic [ZZ_AW-1:0] addr,
  output logic             last
);

  logic [ZZ_AW-1:0] addr_q;

  assign addr = addr_q;
  assign last = (addr_q == ZZ_AW'(ZZ_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (fire) addr_q <= addr_q + 1'b1;
  end

endmodule

// File: rtl/zz_store.sv
module zz_store #(
  parameter int W     = 12,
  parameter int AW    = 6,
  parameter int BANKS = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(BANKS)-1:0] wbank,
  input  logic [AW-1:0]            waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(BANKS)-1:0] rbank,
  input  logic [AW-1:0]            raddr,
  output logic [W-1:0]             rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] rd_bank [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (wbank == b)) mem[waddr] <= wdata;
    end

    assign rd_bank[b] = mem[raddr];
  end

  assign rdata = rd_bank[rbank];

endmodule

// File: rtl/zigzag_reorder.sv
module zigzag_reorder
  import zz_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sob,
  input  logic [COEF_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] out_data,
  output logic              out_last
);

  localparam int AW = ZZ_AW;

  logic          wbank_q;
  logic          rbank_q;
  logic [1:0]    full_q;
  logic          in_fire;
  logic          out_fire;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          wr_done;
  logic          rd_last;

  assign in_ready  = !full_q[wbank_q];
  assign out_valid = full_q[rbank_q];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_last  = out_valid && rd_last;

  zz_wr_seq u_wr (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (in_fire),
    .sob  (in_sob),
    .addr (waddr),
    .done (wr_done)
  );

  zz_rd_seq u_rd (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (out_fire),
    .addr (raddr),
    .last (rd_last)
  );

  zz_store #(.W(COEF_W), .AW(AW), .BANKS(2)) u_mem (
    .clk  (clk),
    .we   (in_fire),
    .wbank(wbank_q),
    .waddr(waddr),
    .wdata(in_data),
    .rbank(rbank_q),
    .raddr(raddr),
    .rdata(out_data)
  );

  // The filling bank and the draining bank always differ when they
  // change in the same cycle, so setting and clearing never collide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank_q <= 1'b0;
      rbank_q <= 1'b0;
      full_q  <= '0;
    end else begin
      if (wr_done) begin
        full_q[wbank_q] <= 1'b1;
        wbank_q         <= ~wbank_q;
      end
      if (out_fire && rd_last) begin
        full_q[rbank_q] <= 1'b0;
        rbank_q         <= ~rbank_q;
      end
    end
  end

endmodule

// File: rtl/zz_reorder_chk.sv
module zz_reorder_chk #(
  parameter int COEF_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sob,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] out_data,
  input logic              out_last
);

  logic [5:0] in_idx;
  logic [5:0] in_cur;
  logic [5:0] out_cnt;
  logic [1:0] pending;
  logic       in_fire;
  logic       out_fire;
  logic       blk_in;
  logic       blk_out;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign in_cur   = in_sob ? 6'd0 : in_idx;
  assign blk_in   = in_fire && (in_cur == 6'd63);
  assign blk_out  = out_fire && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_idx  <= '0;
      out_cnt <= '0;
      pending <= '0;
    end else begin
      if (in_fire) in_idx <= in_cur + 6'd1;
      if (out_fire) out_cnt <= out_cnt + 6'd1;
      pending <= pending + {1'b0, blk_in} - {1'b0, blk_out};
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid && in_ready);
    end
  end

  p_last_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_cnt == 6'd63)));

  p_first_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_in |=> out_valid);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == 2'd2) |-> !in_ready);

  p_pending_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pending != 2'd3));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind zigzag_reorder zz_reorder_chk #(.COEF_W(COEF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sob   (in_sob),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/zigzag_reorder_test.sv
`timescale 1ns/1ps
module zigzag_reorder_test;

  localparam int W = 12;
  localparam int MAXQ = 512;

  // Natural index n -> scan position.
  localparam int ZZ_TAB [64] = '{
    0, 1, 5, 6,14,15,27,28,  2, 4, 7,13,16,26,29,42,
    3, 8,12,17,25,30,41,43,  9,11,18,24,31,40,44,53,
   10,19,23,32,39,45,52,54, 20,22,33,38,46,51,55,60,
   21,34,37,47,50,56,59,61, 35,36,48,49,57,58,62,63};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sob = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         out_last;

  always #2 clk = ~clk;

  zigzag_reorder #(.COEF_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;
  int inv [64];
  logic [W-1:0] tx_d [MAXQ];
  logic         tx_s [MAXQ];
  int tx_n = 0, tx_ptr = 0;
  logic [W-1:0] rx_d [MAXQ];
  logic         rx_l [MAXQ];
  int rx_cyc [MAXQ];
  int in_cyc [MAXQ];
  int rx_n = 0;
  int cyc = 0;
  bit gap_mode = 0;
  int rdy_mode = 0;  // 0 always, 1 never, 2 alternate
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    in_valid  = (tx_ptr < tx_n) && !(gap_mode && (cyc % 3 == 0));
    in_data   = (tx_ptr < MAXQ) ? tx_d[tx_ptr] : '0;
    in_sob    = (tx_ptr < MAXQ) ? tx_s[tx_ptr] : 1'b0;
    out_ready = (rdy_mode == 0) || (rdy_mode == 2 && cyc[0]);
    if (in_valid && in_ready) begin
      in_cyc[tx_ptr] = cyc;
      tx_ptr++;
    end
    if (out_valid && out_ready && rx_n < MAXQ) begin
      rx_d[rx_n]   = out_data;
      rx_l[rx_n]   = out_last;
      rx_cyc[rx_n] = cyc;
      rx_n++;
    end
  endtask

  task automatic add_samples(input int base, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      tx_d[tx_n] = W'(base + i);
      tx_s[tx_n] = (i == 0);
      tx_n++;
    end
  endtask

  task automatic run_until(input int n, input int lim);
    int k;
    k = lim;
    while (rx_n < n && k > 0) begin
      cycle();
      k--;
    end
  endtask

  task automatic clear_queues();
    tx_n = 0; tx_ptr = 0; rx_n = 0;
  endtask

  // Check one received block against the scan table (R2, R3).
  task automatic check_block(input int blk, input int base, input string tag);
    int bad_d, bad_l, first_p, first_a, first_e;
    bad_d = 0; bad_l = 0; first_p = -1; first_a = 0; first_e = 0;
    for (int p = 0; p < 64; p++) begin
      int e;
      e = (base + inv[p]) % (1 << W);
      if (int'(rx_d[blk*64+p]) != e) begin
        if (first_p < 0) begin first_p = p; first_a = int'(rx_d[blk*64+p]); first_e = e; end
        bad_d++;
      end
      if (rx_l[blk*64+p] != (p == 63)) bad_l++;
    end
    chk(bad_d == 0, {"R2 scan order ", tag}, first_a, first_e);
    chk(int'(rx_d[blk*64+5]) == base + 2, {"R2 sample2->pos5 ", tag}, int'(rx_d[blk*64+5]), base + 2);
    chk(bad_l == 0, {"R3 last flag ", tag}, bad_l, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 64; n++) inv[ZZ_TAB[n]] = n;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 idle after reset", int'(out_valid), 0);

    // R2 R3 R4 R5: three blocks streamed continuously
    clear_queues();
    add_samples(256, 64); add_samples(512, 64); add_samples(768, 64);
    rdy_mode = 0; gap_mode = 0;
    run_until(192, 1000);
    chk(rx_n == 192, "R5 samples out", rx_n, 192);
    check_block(0, 256, "blk0");
    check_block(1, 512, "blk1");
    check_block(2, 768, "blk2");
    chk(rx_cyc[0] == in_cyc[63] + 1, "R4 first output latency", rx_cyc[0], in_cyc[63] + 1);
    begin
      int gaps;
      gaps = 0;
      for (int i = 1; i < 192; i++) if (rx_cyc[i] != rx_cyc[i-1] + 1) gaps++;
      chk(gaps == 0, "R5 back-to-back output", gaps, 0);
    end
    repeat (5) cycle();

    // R6 R7: output stalled, three blocks offered
    clear_queues();
    add_samples(1024, 64); add_samples(1280, 64); add_samples(1536, 64);
    rdy_mode = 1;
    repeat (300) cycle();
    chk(tx_ptr == 128, "R6 accepted while stalled", tx_ptr, 128);
    chk(in_ready == 1'b0, "R6 in_ready low when full", int'(in_ready), 0);
    begin
      logic [W-1:0] held;
      held = out_data;
      repeat (10) cycle();
      chk(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      chk(out_data == held, "R7 data held", int'(out_data), int'(held));
      chk(out_data == W'(1024), "R7 held value is position 0", int'(out_data), 1024);
    end
    rdy_mode = 0;
    run_until(192, 2000);
    chk(rx_n == 192, "R6 all blocks after release", rx_n, 192);
    check_block(0, 1024, "stall0");
    check_block(1, 1280, "stall1");
    check_block(2, 1536, "stall2");
    repeat (5) cycle();

    // R9: input gaps with alternating output ready
    clear_queues();
    add_samples(1792, 64); add_samples(2048, 64);
    gap_mode = 1; rdy_mode = 2;
    run_until(128, 3000);
    chk(rx_n == 128, "R9 samples out", rx_n, 128);
    check_block(0, 1792, "R9 gap0");
    check_block(1, 2048, "R9 gap1");
    gap_mode = 0; rdy_mode = 0;
    repeat (5) cycle();

    // R8: partial block then a new start marker
    clear_queues();
    add_samples(2304, 20); add_samples(2560, 64);
    run_until(64, 1000);
    chk(rx_n == 64, "R8 one block out", rx_n, 64);
    check_block(0, 2560, "R8 resync");
    repeat (200) cycle();
    chk(rx_n == 64, "R8 partial block dropped", rx_n, 64);
    chk(out_valid == 1'b0, "R8 nothing pending", int'(out_valid), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule